// File: doc/BRIEF.md
# Sparse Weight-Block Dot-Product Unit with Zero-Run Lookahead

This unit sits beside a processor core and answers custom register-to-register instructions. Every instruction carries two 32-bit source operands and a 7-bit function field. For the multiply-accumulate operation, the first operand holds four signed 8-bit activations. The second operand holds one block of four signed 8-bit weights. The unit multiplies lane by lane, adds the four products into a 32-bit running accumulator, and returns a small count to the destination register.

That count is not computed. It is read from bits that an offline pass planted inside the weight block. The lowest bit of each weight is set aside, and together the four bits state how many all-zero weight blocks come right after this one. Those zero blocks are never sent to the unit. The calling loop adds the returned count to its block index and moves straight to the next block that has work in it. The tag bits are cleared before multiplication, so each weight keeps seven bits of magnitude with an even value.

Two more operations complete the set. One clears the accumulator and the other returns it. Commands and responses each use a valid/ready handshake, and at most one command is in flight at any time.

Top module: `sbm_mac_top`

## Requirements
- R1: After reset, rsp_valid is 0, cmd_ready is 1, and the accumulator reads 0.
- R2: cmd_ready is 0 whenever a response is pending. A command offered during that time is ignored and does not change the accumulator.
- R3: A command accepted at a clock edge (cmd_valid and cmd_ready both 1) raises rsp_valid at that same edge, so the response is visible in the next cycle.
- R4: A response stays valid with unchanged rsp_data until the edge where rsp_ready is 1. rsp_valid is 0 after that edge.
- R5: funct7 = 1 (MAC) returns the lookahead count in rsp_data[3:0], and rsp_data[31:4] is 0. Count bit i is bit 8*i of the weight operand, where weight lane i occupies cmd_rs2[8*i+7:8*i]. The count covers the full range 0 to 15 and is never clamped.
- R6: MAC adds the sum of four signed products to the accumulator. Lane i multiplies cmd_rs1[8*i+7:8*i] by lane i of the weight operand with its bit 0 forced to 0.
- R7: funct7 = 0 (CLEAR) sets the accumulator to 0 and returns 0.
- R8: funct7 = 2 (READ) returns the accumulator value, including every earlier MAC, and leaves the accumulator unchanged.
- R9: The accumulator is 32-bit two's complement and wraps on overflow.
- R10: Any other funct7 value returns 0 and leaves the accumulator unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| cmd_valid | input | 1 | A command is offered |
| cmd_ready | output | 1 | The unit can take a command |
| cmd_funct7 | input | 7 | Operation select: 0 clear, 1 MAC, 2 read |
| cmd_rs1 | input | 32 | Four signed 8-bit activations |
| cmd_rs2 | input | 32 | Weight block: four signed 8-bit weights, each with its bit 0 used as a count tag |
| rsp_valid | output | 1 | The response is valid |
| rsp_ready | input | 1 | The consumer takes the response |
| rsp_data | output | 32 | Result for the destination register |

## Verification
The bench issues a weight block that mixes a negative weight with odd tag bits. A design that multiplied unmasked weights, or packed the count bits in the wrong order, would return the wrong sum or the wrong count. Blocks of all -128 weights and activations are repeated until the accumulator passes 2^31. A design that saturated the sum, or lost the sign extension of the products, would read back something other than 0x80000000. The bench holds rsp_ready low for several cycles while it offers a clear command. A unit that let that command through, or changed rsp_data while stalled, would corrupt the next read. Count values of 15 and 0 are checked, as well as an undefined function code, which must leave the sum alone.

// File: rtl/sbm_pkg.sv
`timescale 1ns/1ps
package sbm_pkg;
    localparam int LANES  = 4;
    localparam int LANE_W = 8;
    localparam int WORD_W = LANES * LANE_W;
    localparam int ACC_W  = 32;
    localparam int F7_W   = 7;
    localparam int PROD_W = 2 * LANE_W;
    localparam int SKIP_W = LANES;

    typedef enum logic [F7_W-1:0] {
        OP_CLEAR = 7'd0,
        OP_MAC   = 7'd1,
        OP_READ  = 7'd2
    } op_e;

    typedef enum logic [1:0] {
        K_CLEAR,
        K_MAC,
        K_READ,
        K_NONE
    } kind_e;

    typedef struct packed {
        kind_e              kind;
        logic [SKIP_W-1:0]  skip;
    } cmd_info_t;

    function automatic kind_e decode_op(input logic [F7_W-1:0] f7);
        case (f7)
            OP_CLEAR: return K_CLEAR;
            OP_MAC:   return K_MAC;
            OP_READ:  return K_READ;
            default:  return K_NONE;
        endcase
    endfunction

    function automatic logic [LANE_W-1:0] strip_tag(input logic [LANE_W-1:0] w);
        return {w[LANE_W-1:1], 1'b0};
    endfunction
endpackage

// File: rtl/sbm_unpack.sv
`timescale 1ns/1ps
module sbm_unpack
    import sbm_pkg::*;
#(
    parameter int N_LANE = LANES,
    parameter int L_W    = LANE_W,
    localparam int B_W   = N_LANE * L_W
) (
    input  logic [B_W-1:0]               blk,
    output logic [N_LANE-1:0][L_W-1:0]   wgt,
    output logic [N_LANE-1:0]            tag
);
    for (genvar g = 0; g < N_LANE; g++) begin : g_lane
        assign wgt[g] = strip_tag(blk[g*L_W +: L_W]);
        assign tag[g] = blk[g*L_W];
    end
endmodule

// File: rtl/sbm_dot.sv
`timescale 1ns/1ps
module sbm_dot
    import sbm_pkg::*;
#(
    parameter int N_LANE = LANES,
    parameter int L_W    = LANE_W,
    parameter int S_W    = ACC_W,
    localparam int B_W   = N_LANE * L_W,
    localparam int P_W   = 2 * L_W
) (
    input  logic [B_W-1:0]             act,
    input  logic [N_LANE-1:0][L_W-1:0] wgt,
    output logic signed [S_W-1:0]      sum
);
    logic signed [P_W-1:0] prod [N_LANE];

    for (genvar g = 0; g < N_LANE; g++) begin : g_mul
        logic signed [L_W-1:0] a_s;
        logic signed [L_W-1:0] w_s;
        assign a_s = act[g*L_W +: L_W];
        assign w_s = wgt[g];
        assign prod[g] = a_s * w_s;
    end

    always_comb begin
        sum = '0;
        for (int i = 0; i < N_LANE; i++) begin
            sum = sum + S_W'(prod[i]);
        end
    end
endmodule

// File: rtl/sbm_hs.sv
`timescale 1ns/1ps
module sbm_hs (
    input  logic clk,
    input  logic rst,
    input  logic cmd_valid,
    input  logic rsp_ready,
    output logic cmd_ready,
    output logic take,
    output logic rsp_valid
);
    logic pend_q;

    assign cmd_ready = !pend_q;
    assign take      = cmd_valid && !pend_q;
    assign rsp_valid = pend_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            pend_q <= 1'b0;
        end else if (take) begin
            pend_q <= 1'b1;
        end else if (pend_q && rsp_ready) begin
            pend_q <= 1'b0;
        end
    end
endmodule

// File: rtl/sbm_mac_top.sv
`timescale 1ns/1ps
module sbm_mac_top
    import sbm_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              cmd_valid,
    output logic              cmd_ready,
    input  logic [F7_W-1:0]   cmd_funct7,
    input  logic [WORD_W-1:0] cmd_rs1,
    input  logic [WORD_W-1:0] cmd_rs2,
    output logic              rsp_valid,
    input  logic              rsp_ready,
    output logic [ACC_W-1:0]  rsp_data
);
    logic                      take;
    logic [LANES-1:0][LANE_W-1:0] wgt;
    logic [SKIP_W-1:0]         tag;
    logic signed [ACC_W-1:0]   dot;
    logic signed [ACC_W-1:0]   acc_q;
    logic [ACC_W-1:0]          data_q;
    cmd_info_t                 info;

    sbm_hs u_hs (
        .clk       (clk),
        .rst       (rst),
        .cmd_valid (cmd_valid),
        .rsp_ready (rsp_ready),
        .cmd_ready (cmd_ready),
        .take      (take),
        .rsp_valid (rsp_valid)
    );

    sbm_unpack #(.N_LANE(LANES), .L_W(LANE_W)) u_unpack (
        .blk (cmd_rs2),
        .wgt (wgt),
        .tag (tag)
    );

    sbm_dot #(.N_LANE(LANES), .L_W(LANE_W), .S_W(ACC_W)) u_dot (
        .act (cmd_rs1),
        .wgt (wgt),
        .sum (dot)
    );

    assign info.kind = decode_op(cmd_funct7);
    assign info.skip = tag;

    always_ff @(posedge clk) begin
        if (rst) begin
            acc_q  <= '0;
            data_q <= '0;
        end else if (take) begin
            case (info.kind)
                K_CLEAR: begin
                    acc_q  <= '0;
                    data_q <= '0;
                end
                K_MAC: begin
                    acc_q  <= acc_q + dot;
                    data_q <= ACC_W'(info.skip);
                end
                K_READ:  data_q <= acc_q;
                default: data_q <= '0;
            endcase
        end
    end

    assign rsp_data = data_q;
endmodule

// File: rtl/sbm_mac_chk.sv
`timescale 1ns/1ps
module sbm_mac_chk (
    input logic        clk,
    input logic        rst,
    input logic        cmd_valid,
    input logic        cmd_ready,
    input logic [6:0]  cmd_funct7,
    input logic [31:0] cmd_rs1,
    input logic [31:0] cmd_rs2,
    input logic        rsp_valid,
    input logic        rsp_ready,
    input logic [31:0] rsp_data
);
    p_busy_blocks_r2: assert property (@(posedge clk) disable iff (rst)
        rsp_valid |-> !cmd_ready);

    p_one_cycle_r3: assert property (@(posedge clk) disable iff (rst)
        (cmd_valid && cmd_ready) |=> rsp_valid);

    p_hold_r4: assert property (@(posedge clk) disable iff (rst)
        (rsp_valid && !rsp_ready) |=> (rsp_valid && $stable(rsp_data)));

    p_release_r4: assert property (@(posedge clk) disable iff (rst)
        (rsp_valid && rsp_ready) |=> !rsp_valid);

    p_count_r5: assert property (@(posedge clk) disable iff (rst)
        (cmd_valid && cmd_ready && cmd_funct7 == 7'd1) |=>
        (rsp_data == {28'd0, $past({cmd_rs2[24], cmd_rs2[16], cmd_rs2[8], cmd_rs2[0]})}));

    p_clear_zero_r7: assert property (@(posedge clk) disable iff (rst)
        (cmd_valid && cmd_ready && cmd_funct7 == 7'd0) |=> (rsp_data == 32'd0));

    p_unknown_zero_r10: assert property (@(posedge clk) disable iff (rst)
        (cmd_valid && cmd_ready && cmd_funct7 > 7'd2) |=> (rsp_data == 32'd0));
endmodule

bind sbm_mac_top sbm_mac_chk u_chk (.*);

// File: tb/sbm_mac_top_test.sv
`timescale 1ns/1ps
module sbm_mac_top_test;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        cmd_valid = 1'b0;
    logic        cmd_ready;
    logic [6:0]  cmd_funct7 = '0;
    logic [31:0] cmd_rs1 = '0;
    logic [31:0] cmd_rs2 = '0;
    logic        rsp_valid;
    logic        rsp_ready = 1'b0;
    logic [31:0] rsp_data;

    int checks = 0;
    int fails  = 0;
    bit started = 1'b0;
    bit ended = 1'b0;

    always #2.5 clk = ~clk;

    sbm_mac_top uut (.*);

    task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
        checks++;
        if (got !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, got, exp);
        end
    endtask

    function automatic int ref_dot(input logic [31:0] a, input logic [31:0] w);
        int s = 0;
        for (int i = 0; i < 4; i++) begin
            int x = int'($signed(a[8*i +: 8]));
            int y = int'($signed(w[8*i +: 8]));
            y = y - (y & 1);
            s += x * y;
        end
        return s;
    endfunction

    function automatic int ref_skip(input logic [31:0] w);
        int k = 0;
        for (int i = 0; i < 4; i++) k += int'(w[8*i]) << i;
        return k;
    endfunction

    // behavioural reference model, updated at every rising edge
    bit m_valid = 1'b0;
    bit m_busy  = 1'b0;
    int m_acc   = 0;
    int m_data  = 0;

    always @(posedge clk) begin
        if (rst) begin
            m_valid = 1'b0;
            m_acc   = 0;
            m_data  = 0;
        end else begin
            m_busy = m_valid;
            if (m_valid && rsp_ready) m_valid = 1'b0;
            if (cmd_valid && !m_busy) begin
                m_valid = 1'b1;
                case (cmd_funct7)
                    7'd0: begin m_acc = 0; m_data = 0; end
                    7'd1: begin m_acc = m_acc + ref_dot(cmd_rs1, cmd_rs2); m_data = ref_skip(cmd_rs2); end
                    7'd2: m_data = m_acc;
                    default: m_data = 0;
                endcase
            end
        end
    end

    always @(negedge clk) begin
        if (started && !rst) begin
            chk("R3 rsp_valid vs model", 32'(rsp_valid), 32'(m_valid));
            chk("R2 cmd_ready vs model", 32'(cmd_ready), 32'(!m_valid));
            if (m_valid) chk("R4 rsp_data vs model", rsp_data, m_data);
        end
    end

    task automatic issue(input logic [6:0] f7, input logic [31:0] a, input logic [31:0] w,
                         input int hold, input bit poke, output logic [31:0] got);
        @(negedge clk);
        cmd_valid = 1'b1; cmd_funct7 = f7; cmd_rs1 = a; cmd_rs2 = w;
        @(posedge clk);
        @(negedge clk);
        if (poke) begin
            cmd_funct7 = 7'd0; cmd_rs1 = 32'hFFFF_FFFF; cmd_rs2 = 32'hFFFF_FFFF;
        end else begin
            cmd_valid = 1'b0;
        end
        for (int h = 0; h < hold; h++) @(negedge clk);
        got = rsp_data;
        cmd_valid = 1'b0;
        rsp_ready = 1'b1;
        @(negedge clk);
        rsp_ready = 1'b0;
    endtask

    task automatic finish_run();
        if (!ended) begin
            ended = 1'b1;
            $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        fails++;
        $display("FAIL R3 watchdog actual=hung expected=done");
        finish_run();
    end

    initial begin
        logic [31:0] r;
        repeat (4) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        started = 1'b1;
        chk("R1 rsp_valid after reset", 32'(rsp_valid), 32'd0);
        chk("R1 cmd_ready after reset", 32'(cmd_ready), 32'd1);
        issue(7'd2, 0, 0, 0, 0, r);
        chk("R1 accumulator after reset", r, 32'd0);

        // lanes: act 1,2,3,4; weights 2,3,-1,5 -> masked 2,2,-2,4; tags 0,1,1,1
        issue(7'd1, 32'h0403_0201, 32'h05FF_0302, 0, 0, r);
        chk("R5 count from tag bits", r, 32'd14);
        issue(7'd2, 0, 0, 0, 0, r);
        chk("R6 masked signed dot", r, 32'd16);

        // stalled response with a clear offered meanwhile
        issue(7'd1, 32'h0101_0101, 32'h0101_0101, 4, 1, r);
        chk("R5 count 15 unclamped", r, 32'd15);
        issue(7'd2, 0, 0, 0, 0, r);
        chk("R2 clear while busy ignored", r, 32'd16);
        issue(7'd2, 0, 0, 2, 0, r);
        chk("R8 read leaves accumulator", r, 32'd16);

        issue(7'd5, 32'h7F7F_7F7F, 32'h7F7F_7F7F, 0, 0, r);
        chk("R10 unknown op returns 0", r, 32'd0);
        issue(7'd2, 0, 0, 0, 0, r);
        chk("R10 unknown op leaves sum", r, 32'd16);

        issue(7'd0, 0, 0, 1, 0, r);
        chk("R7 clear returns 0", r, 32'd0);
        issue(7'd2, 0, 0, 0, 0, r);
        chk("R7 accumulator cleared", r, 32'd0);

        issue(7'd1, 32'h8080_8080, 32'h8080_8080, 0, 0, r);
        chk("R5 count 0", r, 32'd0);
        issue(7'd2, 0, 0, 0, 0, r);
        chk("R6 most negative lanes", r, 32'd65536);

        for (int k = 1; k < 32768; k++) issue(7'd1, 32'h8080_8080, 32'h8080_8080, 0, 0, r);
        issue(7'd2, 0, 0, 0, 0, r);
        chk("R9 wrap to minimum", r, 32'h8000_0000);
        issue(7'd1, 32'h8080_8080, 32'h8080_8080, 0, 0, r);
        issue(7'd2, 0, 0, 0, 0, r);
        chk("R9 continue after wrap", r, 32'h8001_0000);

        finish_run();
    end
endmodule